// File: doc/BRIEF.md
# Card Poll Transaction Controller

This block runs the reader side of a contactless card poll exchange. On a start pulse it waits a fixed number of ticks of an external free-running timer. It then streams the poll request into a byte-wide transmit interface. The request is framed by runs of zero bytes: a leading preamble and a short trailing gap. After the last byte it clears the receive deframer and watches for a finished frame. A per-attempt budget of received bytes bounds the wait.

The block retries when a window ends without a frame, or when a frame arrives with a failed check sum. The number of attempts is bounded. A frame with a good check sum ends the retry loop. The block then reads the response code and the card identifier through the deframer's frame-byte read port, which has one cycle of read latency. It finishes with a one-cycle done pulse, a 2-bit result code and, on success, the 64-bit identifier. Only one card is assumed to be in range, so there is no collision resolution.

Top module: `poll_xact_ctrl`

## Requirements
- R1: While reset is high and after it is released, done, status, tx_valid, dfr_clear and card_id are all zero.
- R2: A start pulse is only taken when the block is idle. A start pulse during a transaction does not restart it and does not add attempts or done pulses.
- R3: Each attempt presents its first transmit byte only after exactly START_DELAY timer_tick pulses have been sampled since the transaction was accepted, or since the previous attempt ended.
- R4: Each attempt sends PRE_LEN bytes of 0x00, then the ten request bytes B2 4D 06 00 FF FF 00 00 09 21 in that order, then POST_LEN bytes of 0x00. A byte is transferred only in a cycle where tx_valid and tx_ready are both high. tx_data holds steady while tx_valid is high and tx_ready is low.
- R5: After the last byte of an attempt, dfr_clear is high for exactly one cycle and never overlaps tx_valid. One transaction makes at most MAX_TRIES attempts.
- R6: An attempt times out once RX_LIMIT rx_byte_stb pulses have been counted since the clear without dfr_full. If dfr_full arrives after RX_LIMIT-1 pulses, the frame is still accepted.
- R7: dfr_full with dfr_crc_ok low ends the attempt early as a failure, and the next attempt follows.
- R8: dfr_full with dfr_crc_ok high ends the retry loop. If frame byte 3 is not 0x01, the result is status 2 and no further attempt is made.
- R9: When every attempt fails, status is 3 if the final attempt ended on a bad check sum and 1 if it ended on a timeout.
- R10: On success, status is 0 and card_id holds frame bytes 4 to 11, with byte 4 in bits 63:56 and byte 11 in bits 7:0.
- R11: done is a single-cycle pulse. card_id clears when a start is accepted, is loaded only together with a success done, and is zero whenever done reports a failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a poll transaction (pulse) |
| timer_tick | input | 1 | One pulse per tick of the free-running timer |
| tx_data | output | 8 | Transmit byte |
| tx_valid | output | 1 | Transmit byte is valid |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| rx_byte_stb | input | 1 | One pulse per byte received by the deframer |
| dfr_clear | output | 1 | Resets the deframer before a wait window |
| dfr_full | input | 1 | Deframer holds a complete frame |
| dfr_crc_ok | input | 1 | Check sum residue of the held frame is zero |
| dfr_rd_addr | output | 9 | Frame-byte read address |
| dfr_rd_data | input | 8 | Frame byte, one cycle after the address |
| done | output | 1 | Transaction finished (pulse) |
| status | output | 2 | 0 ok, 1 timeout, 2 wrong response code, 3 bad check sum |
| card_id | output | 64 | Card identifier |

## Verification
The bench builds the block with MAX_TRIES=3, RX_LIMIT=12 and START_DELAY=3, keeping the default preamble and trailer lengths. Three attempts let it sweep all 64 combinations of per-attempt outcomes (timeout, bad check sum, good frame, good frame one byte short of the limit). Every path to each result code is reached, including a failure on the last attempt that follows a different kind of failure earlier. The small byte budget makes the exact limit boundary cheap to hit. A further sweep over response-code values covers the wrong-acknowledge path with a varying identifier pattern.

// File: rtl/poll_xact_pkg.sv
`timescale 1ns/1ps
package poll_xact_pkg;

  typedef enum logic [1:0] {
    PS_OK      = 2'd0,
    PS_TIMEOUT = 2'd1,
    PS_BADCODE = 2'd2,
    PS_BADCRC  = 2'd3
  } poll_status_e;

  typedef enum logic [2:0] {
    C_IDLE,
    C_DELAY,
    C_SEND,
    C_LISTEN,
    C_READ
  } ctrl_state_e;

  localparam int unsigned REQ_LEN = 10;

  // fixed poll request, check sum already appended
  function automatic logic [7:0] req_byte(input logic [3:0] i);
    case (i)
      4'd0:    return 8'hB2;
      4'd1:    return 8'h4D;
      4'd2:    return 8'h06;
      4'd3:    return 8'h00;
      4'd4:    return 8'hFF;
      4'd5:    return 8'hFF;
      4'd6:    return 8'h00;
      4'd7:    return 8'h00;
      4'd8:    return 8'h09;
      4'd9:    return 8'h21;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/poll_xact_tx_seq.sv
`timescale 1ns/1ps
module poll_xact_tx_seq #(
  parameter int PRE_LEN  = 6,
  parameter int POST_LEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       launch,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       sent
);
  import poll_xact_pkg::*;

  localparam int TOTAL = PRE_LEN + int'(REQ_LEN) + POST_LEN;
  localparam int IW    = $clog2(TOTAL);

  logic          active;
  logic [IW-1:0] idx;

  function automatic logic [7:0] byte_at(input logic [IW-1:0] i);
    logic [IW-1:0] off;
    off = i - IW'(PRE_LEN);
    if (i < IW'(PRE_LEN))
      return 8'h00;
    else if (i < IW'(PRE_LEN + int'(REQ_LEN)))
      return req_byte(off[3:0]);
    else
      return 8'h00;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      idx     <= '0;
      tx_data <= 8'h00;
      sent    <= 1'b0;
    end else begin
      sent <= 1'b0;
      if (!active) begin
        if (launch) begin
          active  <= 1'b1;
          idx     <= '0;
          tx_data <= byte_at('0);
        end
      end else if (tx_ready) begin
        if (idx == IW'(TOTAL - 1)) begin
          active <= 1'b0;
          sent   <= 1'b1;
        end else begin
          idx     <= idx + 1'b1;
          tx_data <= byte_at(idx + 1'b1);
        end
      end
    end
  end

  assign tx_valid = active;

endmodule

// File: rtl/poll_xact_rx_watch.sv
`timescale 1ns/1ps
module poll_xact_rx_watch #(
  parameter int RX_LIMIT = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic rx_stb,
  output logic expired
);
  localparam int CW = $clog2(RX_LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (rx_stb && cnt != CW'(RX_LIMIT))
      cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == CW'(RX_LIMIT));

endmodule

// File: rtl/poll_xact_id_grab.sv
`timescale 1ns/1ps
module poll_xact_id_grab #(
  parameter int          AW       = 9,
  parameter int          CODE_POS = 3,
  parameter int          ID_BYTES = 8,
  parameter logic [7:0]  ACK_CODE = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fetch,
  output logic [AW-1:0]         rd_addr,
  input  logic [7:0]            rd_data,
  output logic                  code_bad,
  output logic                  id_ok,
  output logic [8*ID_BYTES-1:0] id_val
);
  localparam int LAST_POS = CODE_POS + ID_BYTES;
  localparam int IDW      = 8 * ID_BYTES;

  logic          issuing;
  logic          vld;
  logic [AW-1:0] tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      issuing  <= 1'b0;
      vld      <= 1'b0;
      tag      <= '0;
      rd_addr  <= '0;
      id_val   <= '0;
      code_bad <= 1'b0;
      id_ok    <= 1'b0;
    end else begin
      code_bad <= 1'b0;
      id_ok    <= 1'b0;
      vld      <= issuing;
      tag      <= rd_addr;
      if (fetch) begin
        issuing <= 1'b1;
        rd_addr <= AW'(CODE_POS);
        id_val  <= '0;
        vld     <= 1'b0;
      end else if (issuing) begin
        if (rd_addr == AW'(LAST_POS))
          issuing <= 1'b0;
        else
          rd_addr <= rd_addr + 1'b1;
      end
      if (vld) begin
        if (tag == AW'(CODE_POS)) begin
          if (rd_data != ACK_CODE) begin
            code_bad <= 1'b1;
            issuing  <= 1'b0;
            vld      <= 1'b0;
          end
        end else begin
          id_val <= {id_val[IDW-9:0], rd_data};
          if (tag == AW'(LAST_POS))
            id_ok <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/poll_xact_ctrl.sv
`timescale 1ns/1ps
module poll_xact_ctrl #(
  parameter int         MAX_TRIES   = 20,
  parameter int         RX_LIMIT    = 512,
  parameter int         START_DELAY = 8,
  parameter int         PRE_LEN     = 6,
  parameter int         POST_LEN    = 2,
  parameter int         AW          = 9,
  parameter int         ID_BYTES    = 8,
  parameter int         CODE_POS    = 3,
  parameter logic [7:0] ACK_CODE    = 8'h01
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  timer_tick,
  output logic [7:0]            tx_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  input  logic                  rx_byte_stb,
  output logic                  dfr_clear,
  input  logic                  dfr_full,
  input  logic                  dfr_crc_ok,
  output logic [AW-1:0]         dfr_rd_addr,
  input  logic [7:0]            dfr_rd_data,
  output logic                  done,
  output logic [1:0]            status,
  output logic [8*ID_BYTES-1:0] card_id
);
  import poll_xact_pkg::*;

  localparam int TW = $clog2(MAX_TRIES + 1);
  localparam int DW = $clog2(START_DELAY + 1);

  ctrl_state_e           state;
  logic [TW-1:0]         tries;
  logic [DW-1:0]         dly;
  logic                  launch;
  logic                  fetch;
  logic                  sent;
  logic                  expired;
  logic                  code_bad;
  logic                  id_ok;
  logic [8*ID_BYTES-1:0] id_val;

  poll_xact_tx_seq #(
    .PRE_LEN (PRE_LEN),
    .POST_LEN(POST_LEN)
  ) u_tx (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .tx_ready(tx_ready),
    .tx_valid(tx_valid),
    .tx_data (tx_data),
    .sent    (sent)
  );

  poll_xact_rx_watch #(
    .RX_LIMIT(RX_LIMIT)
  ) u_rxw (
    .clk    (clk),
    .rst    (rst),
    .clear  (dfr_clear),
    .rx_stb (rx_byte_stb),
    .expired(expired)
  );

  poll_xact_id_grab #(
    .AW      (AW),
    .CODE_POS(CODE_POS),
    .ID_BYTES(ID_BYTES),
    .ACK_CODE(ACK_CODE)
  ) u_id (
    .clk     (clk),
    .rst     (rst),
    .fetch   (fetch),
    .rd_addr (dfr_rd_addr),
    .rd_data (dfr_rd_data),
    .code_bad(code_bad),
    .id_ok   (id_ok),
    .id_val  (id_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= C_IDLE;
      tries     <= '0;
      dly       <= '0;
      launch    <= 1'b0;
      fetch     <= 1'b0;
      dfr_clear <= 1'b0;
      done      <= 1'b0;
      status    <= PS_OK;
      card_id   <= '0;
    end else begin
      launch    <= 1'b0;
      fetch     <= 1'b0;
      dfr_clear <= 1'b0;
      done      <= 1'b0;
      case (state)
        C_IDLE: begin
          if (start) begin
            tries   <= '0;
            dly     <= '0;
            card_id <= '0;
            state   <= C_DELAY;
          end
        end
        C_DELAY: begin
          if (timer_tick) begin
            if (dly == DW'(START_DELAY - 1)) begin
              launch <= 1'b1;
              state  <= C_SEND;
            end else begin
              dly <= dly + 1'b1;
            end
          end
        end
        C_SEND: begin
          if (sent) begin
            dfr_clear <= 1'b1;
            state     <= C_LISTEN;
          end
        end
        C_LISTEN: begin
          if (!dfr_clear) begin
            if (dfr_full && dfr_crc_ok) begin
              fetch <= 1'b1;
              state <= C_READ;
            end else if (dfr_full || expired) begin
              if (tries == TW'(MAX_TRIES - 1)) begin
                done   <= 1'b1;
                status <= dfr_full ? PS_BADCRC : PS_TIMEOUT;
                state  <= C_IDLE;
              end else begin
                tries <= tries + 1'b1;
                dly   <= '0;
                state <= C_DELAY;
              end
            end
          end
        end
        C_READ: begin
          if (code_bad) begin
            done   <= 1'b1;
            status <= PS_BADCODE;
            state  <= C_IDLE;
          end else if (id_ok) begin
            done    <= 1'b1;
            status  <= PS_OK;
            card_id <= id_val;
            state   <= C_IDLE;
          end
        end
        default: state <= C_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/poll_xact_ctrl_chk.sv
`timescale 1ns/1ps
module poll_xact_ctrl_chk #(
  parameter int MAX_TRIES = 20,
  parameter int IDW       = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           start,
  input logic           tx_valid,
  input logic           tx_ready,
  input logic [7:0]     tx_data,
  input logic           dfr_clear,
  input logic           done,
  input logic [1:0]     status,
  input logic [IDW-1:0] card_id
);
  localparam int NW = $clog2(MAX_TRIES + 2);

  logic [NW-1:0] clr_cnt;

  always_ff @(posedge clk) begin
    if (rst || done)
      clr_cnt <= '0;
    else if (dfr_clear)
      clr_cnt <= clr_cnt + 1'b1;
  end

  a_r4_hold_byte: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  a_r5_clear_apart: assert property (@(posedge clk) disable iff (rst)
    !(dfr_clear && tx_valid));

  a_r5_attempt_bound: assert property (@(posedge clk) disable iff (rst)
    clr_cnt <= NW'(MAX_TRIES));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_id_zero_on_fail: assert property (@(posedge clk) disable iff (rst)
    (done && status != 2'd0) |-> (card_id == '0));

  a_r11_id_change: assert property (@(posedge clk) disable iff (rst)
    !$stable(card_id) |-> ($past(start) || done));

endmodule

bind poll_xact_ctrl poll_xact_ctrl_chk #(
  .MAX_TRIES(MAX_TRIES),
  .IDW      (8 * ID_BYTES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .dfr_clear(dfr_clear),
  .done     (done),
  .status   (status),
  .card_id  (card_id)
);

// File: tb/poll_xact_ctrl_tb.sv
`timescale 1ns/1ps
module poll_xact_ctrl_tb;
  localparam int TRIES = 3;
  localparam int LIMIT = 12;
  localparam int DLY   = 3;
  localparam int AW    = 9;
  localparam int TOT   = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          timer_tick = 1'b0;
  logic [7:0]    tx_data;
  logic          tx_valid;
  logic          tx_ready = 1'b0;
  logic          rx_byte_stb = 1'b0;
  logic          dfr_clear;
  logic          full_r = 1'b0;
  logic          crc_r = 1'b0;
  logic          set_full = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_data = 8'h00;
  logic          done;
  logic [1:0]    status;
  logic [63:0]   card_id;

  always #10 clk = ~clk;

  poll_xact_ctrl #(
    .MAX_TRIES  (TRIES),
    .RX_LIMIT   (LIMIT),
    .START_DELAY(DLY)
  ) u_dut (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .timer_tick (timer_tick),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_byte_stb(rx_byte_stb),
    .dfr_clear  (dfr_clear),
    .dfr_full   (full_r),
    .dfr_crc_ok (crc_r),
    .dfr_rd_addr(rd_addr),
    .dfr_rd_data(rd_data),
    .done       (done),
    .status     (status),
    .card_id    (card_id)
  );

  int vecs = 0;
  int miss = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // deframer model: frame store with one-cycle read, full flag cleared by dfr_clear
  logic [7:0] fmem [0:31];
  always @(posedge clk) begin
    rd_data <= fmem[rd_addr[4:0]];
    if (rst || dfr_clear) full_r <= 1'b0;
    else if (set_full)    full_r <= 1'b1;
  end

  function automatic logic [7:0] exp_tx(input int p);
    logic [7:0] req [0:9];
    req = '{8'hB2, 8'h4D, 8'h06, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h09, 8'h21};
    if (p < 6) return 8'h00;
    if (p < 16) return req[p-6];
    return 8'h00;
  endfunction

  // tick, ready and monitors, all at the falling edge
  int       tdiv = 0;
  logic [7:0] lf = 8'h5a;
  int       txp = 0;
  int       tk = 0;
  bit       meas_on = 0;
  int       ndone = 0;
  logic [1:0] got_status = 2'd0;

  initial begin
    forever begin
      @(negedge clk);
      timer_tick = (tdiv == 2);
      tdiv = (tdiv == 2) ? 0 : tdiv + 1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      tx_ready = lf[0] | lf[2];
      #1;
      if (!rst) begin
        if (tx_valid && tx_ready) begin
          chk("R4 transmit byte", {56'd0, tx_data}, {56'd0, exp_tx(txp % TOT)});
          txp++;
        end
        if (tx_valid) meas_on = 0;
        else if (meas_on && timer_tick) tk++;
        if (done) begin
          ndone++;
          got_status = status;
        end
      end
    end
  end

  // card/deframer responder
  int kind_q [0:2];
  int att = 0;

  task automatic respond(input int k);
    int n;
    n = (k == 0) ? LIMIT : (k == 3) ? LIMIT - 1 : 3;
    repeat (n) begin
      @(negedge clk); #3;
      rx_byte_stb = 1'b1;
    end
    @(negedge clk); #3;
    rx_byte_stb = 1'b0;
    if (k != 0) begin
      crc_r    = (k != 1);
      set_full = 1'b1;
      @(negedge clk); #3;
      set_full = 1'b0;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk); #3;
      if (!rst && dfr_clear === 1'b1) begin
        int k;
        k = (att < TRIES) ? kind_q[att] : 0;
        att++;
        respond(k);
      end
    end
  end

  bit hung = 0;

  task automatic run_case(input int k0, input int k1, input int k2,
                          input logic [7:0] code, input logic [63:0] id);
    int g;
    int att_exp;
    logic [1:0] st_exp;
    logic [63:0] id_exp;
    int waited;
    int kk [0:2];
    kk = '{k0, k1, k2};
    kind_q = kk;
    fmem[3] = code;
    for (int i = 0; i < 8; i++) fmem[4+i] = id[63-8*i -: 8];
    att = 0; txp = 0; ndone = 0; tk = 0;
    @(negedge clk); #2;
    start = 1'b1; meas_on = 1;
    @(negedge clk); #2;
    start = 1'b0;
    repeat (20) @(negedge clk);
    #2 start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    waited = 0;
    while (ndone == 0 && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    if (ndone == 0) begin
      hung = 1;
      vecs++; miss++;
      $display("FAIL R11 watchdog actual=no done expected=done");
      return;
    end
    repeat (4) @(negedge clk);
    #2;
    g = -1;
    for (int i = TRIES - 1; i >= 0; i--) if (kk[i] == 2 || kk[i] == 3) g = i;
    if (g >= 0) begin
      att_exp = g + 1;
      st_exp  = (code == 8'h01) ? 2'd0 : 2'd2;
    end else begin
      att_exp = TRIES;
      st_exp  = (kk[TRIES-1] == 1) ? 2'd3 : 2'd1;
    end
    id_exp = (st_exp == 2'd0) ? id : 64'd0;
    chk("R8 R9 R10 status", {62'd0, got_status}, {62'd0, st_exp});
    chk("R10 R11 card_id", card_id, id_exp);
    chk("R5 R6 R7 attempts", 64'(att), 64'(att_exp));
    chk("R4 byte total", 64'(txp), 64'(TOT * att_exp));
    chk("R3 ticks before first byte", 64'(tk), 64'(DLY));
    chk("R2 R11 done count", 64'(ndone), 64'd1);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) fmem[i] = 8'(i * 7);
    repeat (4) @(negedge clk);
    #2;
    chk("R1 done in reset", {63'd0, done}, 64'd0);
    chk("R1 tx_valid in reset", {63'd0, tx_valid}, 64'd0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 status after reset", {62'd0, status}, 64'd0);
    chk("R1 dfr_clear after reset", {63'd0, dfr_clear}, 64'd0);
    chk("R1 card_id after reset", card_id, 64'd0);
    for (int a = 0; a < 4 && !hung; a++)
      for (int b = 0; b < 4 && !hung; b++)
        for (int c = 0; c < 4 && !hung; c++) begin
          logic [31:0] s;
          s = 32'(a * 16 + b * 4 + c + 1);
          run_case(a, b, c, 8'h01, {s * 32'h9E3779B1, ~s * 32'h85EBCA6B});
        end
    for (int v = 0; v < 6 && !hung; v++) begin
      logic [7:0] cd;
      cd = (v == 0) ? 8'h00 : (v == 1) ? 8'h02 : (v == 2) ? 8'h03 :
           (v == 3) ? 8'h80 : (v == 4) ? 8'hFF : 8'h11;
      run_case(2, 0, 0, cd, {8{cd ^ 8'h5C}});
      if (!hung) run_case(0, 3, 0, cd, {8{cd ^ 8'hA3}});
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule